// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

The block drives a daisy chain of single-wire addressable RGB LEDs from a byte stream. Commands arrive as five-byte packets on an 8-bit valid/ready input. A store packet places one LED's 24-bit color in an on-chip frame buffer and leaves the strip alone. A transfer packet shifts the whole buffer out on one line. Each bit is encoded as a high pulse followed by a low pulse, and the width of each pulse tells a one from a zero. After the last bit the line is held low long enough for the LEDs to latch the new colors.

Color updates are therefore two-phase: any number of buffered stores, then one explicit transfer of the whole chain. While a transfer and its latch gap are in progress, the block raises busy and stalls the input by holding ready low. Pulse lengths in clock cycles are derived from a clock-frequency parameter. The chain length is a parameter with a default of 8 LEDs.

Top module: `led_chain_drv`

## Requirements
- R1: During and immediately after reset, `led_o` is low, `busy_o` is low and `in_ready_o` is high. Every buffer entry resets to color 0.
- R2: A packet is five accepted bytes, in the order opcode, red, green, blue, LED index. Opcode 0x63 stores {green, red, blue} for the indexed LED at the edge that accepts the fifth byte. A store leaves `led_o` low and `busy_o` low.
- R3: Opcode 0x74 starts a transfer in the cycle after its fifth byte is accepted, and its color and index bytes have no effect. The transfer sends LED 0 first. Each LED's 24 bits go out as green, then red, then blue, each most significant bit first.
- R4: A one bit is `led_o` high for ceil(CLK_HZ·700 ns) cycles and then low for ceil(CLK_HZ·600 ns) cycles. At 200 MHz these are 140 and 120 cycles.
- R5: A zero bit is high for ceil(CLK_HZ·350 ns) cycles and then low for ceil(CLK_HZ·800 ns) cycles. At 200 MHz these are 70 and 160 cycles.
- R6: After the last bit's low time, `led_o` stays low for ceil(CLK_HZ·50 µs) further cycles (10000 at 200 MHz) with `busy_o` still high. `busy_o` falls at the end of this interval.
- R7: A packet whose opcode is neither 0x63 nor 0x74 changes neither the buffer nor the line.
- R8: A store whose index is at or above N_LEDS leaves the buffer unchanged.
- R9: `busy_o` is high from the cycle after a transfer's fifth byte until the latch interval ends. `in_ready_o` is the inverse of `busy_o`, so bytes offered during a transfer are held off and are accepted after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Command byte |
| in_valid_i | input | 1 | Command byte valid |
| in_ready_o | output | 1 | Block can accept a byte |
| busy_o | output | 1 | Transfer or latch interval in progress |
| led_o | output | 1 | Serial line to the first LED |

## Verification
A store takes effect at the edge that accepts its fifth byte. A transfer raises `led_o` and `busy_o` one cycle after that edge. Every pulse then follows for exactly its computed cycle count, and `busy_o` falls one cycle after the last latch cycle. The bench replays each accepted byte in a behavioural model one negative edge after the accepting positive edge. On a transfer, the model expands its own buffer into a per-cycle queue of expected line levels. It pops one entry at every negative edge and compares it with `led_o`, `busy_o` and `in_ready_o`, so each due cycle is checked exactly and no tolerance window is needed. Ignored packets and stores blocked by a stall become visible in the waveform of the next transfer.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

  localparam logic [7:0] OP_STORE = 8'h63;
  localparam logic [7:0] OP_SEND  = 8'h74;

  typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW, ST_LATCH} tx_state_e;

  // ceil(hz * ns / 1e9)
  function automatic longint unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/led_cmd_parser.sv
module led_cmd_parser
  import led_chain_pkg::*;
#(
  parameter int N_LEDS = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             fire_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [23:0]      wr_color_o,
  output logic             start_o
);

  logic [2:0] cnt_q;
  logic [7:0] op_q, red_q, grn_q, blu_q;
  logic       last;

  assign last       = fire_i && (cnt_q == 3'd4);
  assign wr_en_o    = last && (op_q == OP_STORE) && (32'(byte_i) < N_LEDS);
  assign wr_idx_o   = IDX_W'(byte_i);
  assign wr_color_o = {grn_q, red_q, blu_q};
  assign start_o    = last && (op_q == OP_SEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= '0;
      red_q <= '0;
      grn_q <= '0;
      blu_q <= '0;
    end else if (fire_i) begin
      case (cnt_q)
        3'd0:    op_q  <= byte_i;
        3'd1:    red_q <= byte_i;
        3'd2:    grn_q <= byte_i;
        3'd3:    blu_q <= byte_i;
        default: ;
      endcase
      cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
    end
  end

endmodule

// File: rtl/led_color_buf.sv
module led_color_buf #(
  parameter int N_LEDS = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [23:0]      wr_color_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [23:0]      rd_color_o
);

  logic [23:0] ent_q [N_LEDS];

  for (genvar i = 0; i < N_LEDS; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     ent_q[i] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(i)))     ent_q[i] <= wr_color_i;
    end
  end

  assign rd_color_o = ent_q[rd_idx_i];

endmodule

// File: rtl/led_frame_tx.sv
module led_frame_tx
  import led_chain_pkg::*;
#(
  parameter int          N_LEDS    = 8,
  parameter int          IDX_W     = 3,
  parameter int unsigned ONE_HI    = 70,
  parameter int unsigned ONE_LO    = 60,
  parameter int unsigned ZERO_HI   = 35,
  parameter int unsigned ZERO_LO   = 80,
  parameter int unsigned LATCH_LEN = 5000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [23:0]      rd_color_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             line_o,
  output logic             busy_o
);

  localparam int unsigned HI_MAX  = (ONE_HI > ZERO_HI) ? ONE_HI : ZERO_HI;
  localparam int unsigned LO_MAX  = (ONE_LO > ZERO_LO) ? ONE_LO : ZERO_LO;
  localparam int unsigned BIT_MAX = (HI_MAX > LO_MAX) ? HI_MAX : LO_MAX;
  localparam int unsigned CNT_MAX = (BIT_MAX > LATCH_LEN) ? BIT_MAX : LATCH_LEN;
  localparam int          CW      = $clog2(CNT_MAX + 1);
  localparam int unsigned RUN_MAX = LATCH_LEN + LO_MAX + 1;
  localparam int          RW      = $clog2(RUN_MAX + 1);

  localparam logic [CW-1:0] ONE_HI_E  = CW'(ONE_HI - 1);
  localparam logic [CW-1:0] ONE_LO_E  = CW'(ONE_LO - 1);
  localparam logic [CW-1:0] ZERO_HI_E = CW'(ZERO_HI - 1);
  localparam logic [CW-1:0] ZERO_LO_E = CW'(ZERO_LO - 1);
  localparam logic [CW-1:0] LATCH_E   = CW'(LATCH_LEN - 1);

  tx_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0] led_q, led_d;
  logic [4:0]       bit_q, bit_d;
  logic             cur_bit, hi_end, lo_end, last_bit;

  assign rd_idx_o = led_q;
  assign cur_bit  = rd_color_i[bit_q];
  assign hi_end   = cnt_q == (cur_bit ? ONE_HI_E : ZERO_HI_E);
  assign lo_end   = cnt_q == (cur_bit ? ONE_LO_E : ZERO_LO_E);
  assign last_bit = (bit_q == 5'd0) && (led_q == IDX_W'(N_LEDS - 1));
  assign line_o   = state_q == ST_HIGH;
  assign busy_o   = state_q != ST_IDLE;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    led_d   = led_q;
    bit_d   = bit_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i) begin
          state_d = ST_HIGH;
          led_d   = '0;
          bit_d   = 5'd23;
        end
      end
      ST_HIGH: if (hi_end) begin
        state_d = ST_LOW;
        cnt_d   = '0;
      end
      ST_LOW: if (lo_end) begin
        cnt_d = '0;
        if (last_bit) state_d = ST_LATCH;
        else begin
          state_d = ST_HIGH;
          if (bit_q == 5'd0) begin
            bit_d = 5'd23;
            led_d = led_q + IDX_W'(1);
          end else bit_d = bit_q - 5'd1;
        end
      end
      ST_LATCH: if (cnt_q == LATCH_E) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      led_q   <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      led_q   <= led_d;
      bit_q   <= bit_d;
    end
  end

  // cycles the line has held its present level, for the width checks
  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            run_q <= RW'(1);
    else if ((state_d == ST_HIGH) != line_o) run_q <= RW'(1);
    else if (run_q != RW'(RUN_MAX))          run_q <= run_q + RW'(1);
  end

  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_o) |-> ($past(run_q) == RW'(ONE_HI) || $past(run_q) == RW'(ZERO_HI))); // R4

  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(line_o) && $past(busy_o)) |->
      ($past(run_q) == RW'(ONE_LO) || $past(run_q) == RW'(ZERO_LO))); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(run_q) >= RW'(LATCH_LEN) && !$past(line_o))); // R6

endmodule

// File: rtl/led_chain_drv.sv
module led_chain_drv
  import led_chain_pkg::*;
#(
  parameter int              N_LEDS = 8,
  parameter longint unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  output logic       busy_o,
  output logic       led_o
);

  localparam int          IDX_W     = (N_LEDS > 1) ? $clog2(N_LEDS) : 1;
  localparam int unsigned ONE_HI    = int'(ns_to_cyc(CLK_HZ, 700));
  localparam int unsigned ONE_LO    = int'(ns_to_cyc(CLK_HZ, 600));
  localparam int unsigned ZERO_HI   = int'(ns_to_cyc(CLK_HZ, 350));
  localparam int unsigned ZERO_LO   = int'(ns_to_cyc(CLK_HZ, 800));
  localparam int unsigned LATCH_LEN = int'(ns_to_cyc(CLK_HZ, 50_000));

  logic             fire, wr_en, start;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [23:0]      wr_color, rd_color;

  assign in_ready_o = !busy_o;
  assign fire       = in_valid_i && in_ready_o;

  led_cmd_parser #(.N_LEDS(N_LEDS), .IDX_W(IDX_W)) u_parser (
    .clk_i, .rst_ni,
    .byte_i     (in_data_i),
    .fire_i     (fire),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_color_o (wr_color),
    .start_o    (start)
  );

  led_color_buf #(.N_LEDS(N_LEDS), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_color_i (wr_color),
    .rd_idx_i   (rd_idx),
    .rd_color_o (rd_color)
  );

  led_frame_tx #(
    .N_LEDS(N_LEDS), .IDX_W(IDX_W),
    .ONE_HI(ONE_HI), .ONE_LO(ONE_LO), .ZERO_HI(ZERO_HI), .ZERO_LO(ZERO_LO),
    .LATCH_LEN(LATCH_LEN)
  ) u_tx (
    .clk_i, .rst_ni,
    .start_i    (start),
    .rd_color_i (rd_color),
    .rd_idx_o   (rd_idx),
    .line_o     (led_o),
    .busy_o     (busy_o)
  );

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_o); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !led_o); // R2

endmodule

// File: tb/led_chain_drv_tb.sv
`timescale 1ns/1ps
module led_chain_drv_tb;

  localparam int N     = 3;
  localparam int HI1   = 140, LO1 = 120, HI0 = 70, LO0 = 160;
  localparam int LATCH = 10000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready, busy, led;

  always #2.5 clk = ~clk;

  led_chain_drv #(.N_LEDS(N), .CLK_HZ(200_000_000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .busy_o(busy), .led_o(led)
  );

  int          n_cmp = 0, n_bad = 0;
  string       cur_req = "R1";
  logic        model_on = 1'b0;
  logic [7:0]  mb [5];
  int          mcnt = 0;
  logic [23:0] mbuf [N];
  byte unsigned q [$];
  logic        pend = 1'b0;
  logic [7:0]  pend_data;
  logic        exp_busy, exp_led;
  byte unsigned code;
  string       tag;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // codes: 1 one-high, 2 one-low (R4); 3 zero-high, 4 zero-low (R5); 5 latch (R6)
  task automatic expand_frame();
    for (int l = 0; l < N; l++)
      for (int b = 23; b >= 0; b--)
        if (mbuf[l][b]) begin
          repeat (HI1) q.push_back(8'd1);
          repeat (LO1) q.push_back(8'd2);
        end else begin
          repeat (HI0) q.push_back(8'd3);
          repeat (LO0) q.push_back(8'd4);
        end
    repeat (LATCH) q.push_back(8'd5);
  endtask

  always @(negedge clk) if (model_on) begin
    if (pend) begin
      mb[mcnt] = pend_data;
      if (mcnt == 4) begin
        mcnt = 0;
        if (mb[0] == 8'h63 && mb[4] < N) mbuf[mb[4]] = {mb[2], mb[1], mb[3]}; // R2, R8
        else if (mb[0] == 8'h74) expand_frame();                                // R3
      end else mcnt++;
    end
    exp_busy = q.size() != 0;
    if (exp_busy) begin
      code    = q.pop_front();
      exp_led = (code == 1 || code == 3);
      tag     = (code <= 2) ? "R4" : (code <= 4) ? "R5" : "R6";
    end else begin
      exp_led = 1'b0;
      tag     = cur_req;
    end
    chk(tag, "led_o", 32'(led), 32'(exp_led));
    chk("R9", "busy_o", 32'(busy), 32'(exp_busy));
    chk("R9", "in_ready_o", 32'(in_ready), 32'(!exp_busy));
    pend      = in_valid && in_ready;
    pend_data = in_data;
  end

  task automatic send_byte(logic [7:0] d);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(logic [7:0] op, logic [7:0] r, logic [7:0] g, logic [7:0] b, logic [7:0] idx);
    send_byte(op); send_byte(r); send_byte(g); send_byte(b); send_byte(idx);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (busy) @(negedge clk);
    idle(20);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mbuf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset led_o", 32'(led), 32'd0);
    chk("R1", "reset busy_o", 32'(busy), 32'd0);
    chk("R1", "reset in_ready_o", 32'(in_ready), 32'd1);
    @(posedge clk); #1;
    rst_n    = 1'b1;
    model_on = 1'b1;
    idle(5);

    cur_req = "R2";
    send_pkt(8'h63, 8'h12, 8'hA5, 8'hFF, 8'd0);
    send_pkt(8'h63, 8'h00, 8'h00, 8'h01, 8'd1);
    send_pkt(8'h63, 8'hFF, 8'h00, 8'h80, 8'd2);
    idle(20);

    cur_req = "R7";
    send_pkt(8'h55, 8'h00, 8'h00, 8'h00, 8'd0);
    idle(10);
    cur_req = "R8";
    send_pkt(8'h63, 8'hAA, 8'hAA, 8'hAA, 8'd3);
    send_pkt(8'h63, 8'h00, 8'h00, 8'h00, 8'd255);
    idle(10);

    // R3: color and index bytes of the transfer are junk
    cur_req = "R3";
    send_pkt(8'h74, 8'h09, 8'h5A, 8'hC3, 8'd7);
    // R9: this store stalls until the latch ends, then lands
    cur_req = "R9";
    send_pkt(8'h63, 8'h80, 8'h01, 8'h7E, 8'd0);
    wait_done();

    cur_req = "R3";
    send_pkt(8'h74, 8'h00, 8'h00, 8'h00, 8'd0);
    wait_done();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule